// File: doc/BRIEF.md
# Trace Stimulus Write Decoder

This block sits behind a memory-mapped stimulus area. Each bus write carries an address relative to the area base, a data word of up to 64 bits and a byte size. Every channel occupies a 256-byte window of that area. The upper address bits pick the channel. The low eight bits pick the packet kind and its attributes. A write that passes every gate becomes one trace event record on a valid/ready output. The record holds the channel, the kind, three attribute flags, the size and the payload.

Attributes are requested by clearing bits from a kind's base offset, so one window exposes several aliases of each kind. A 32-bit port enable register gates channels by channel number modulo 32. It resets to all ones and is written through a simple write strobe. A global enable, a trigger enable and a 64-bit width option are inputs. Writes that are dropped are still accepted on the bus. When a record is waiting and the consumer stalls, the bus ready signal falls.

Top module: `trace_port_decoder`

## Requirements
- R1: The channel in a record equals the write address divided by 256. Address bits [7:0] are the offset inside the channel window.
- R2: The offset sets the kind. Subsets of the bits of 0x98 give a data packet (kind code 0). 0xE8 with bits 3 and/or 7 cleared gives a flag packet (kind code 1). 0xF8 with bits 3 and/or 7 cleared gives a trigger packet (kind code 2). Any other offset produces no record.
- R3: Clearing offset bit 3 sets the timestamp flag. Clearing bit 7 sets the guaranteed flag. Clearing bit 4 sets the marked flag, and this bit is an option for data packets only. A flag is 0 whenever its bit is left set.
- R4: The size code is 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes. Code 3 is legal only while the 64-bit option is high; an illegal size produces no record. The payload keeps only the low bytes of the write data that the size covers, and the rest reads zero.
- R5: A flag packet always reports size code 0 and carries only data bits [7:0], whatever size the write had.
- R6: Port enable bit n gates every channel whose number modulo 32 is n. The register resets to all ones and takes the value on its write port.
- R7: A trigger packet is produced only while the trigger enable is high. Otherwise the write produces no record.
- R8: A write to a channel at or above NUM_CHAN, or any write while the global enable is low, produces no record and is still accepted.
- R9: A record appears one cycle after its write is accepted. While the record is not taken, it holds stable and the bus ready signal is low.
- R10: After reset, no record is pending and the bus is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global enable |
| trig_en | input | 1 | Enables trigger packets |
| cfg_wide | input | 1 | Allows 8-byte writes |
| pen_we | input | 1 | Port enable register write strobe |
| pen_wdata | input | 32 | Port enable register write value |
| wr_valid | input | 1 | Bus write strobe |
| wr_ready | output | 1 | Bus write accepted when high |
| wr_addr | input | ADDR_W | Address relative to the stimulus area base |
| wr_data | input | 64 | Write data |
| wr_size | input | 2 | Size code, log2 of the byte count |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Consumer takes the record |
| rec_chan | output | ADDR_W-8 | Channel number |
| rec_kind | output | 2 | 0 data, 1 flag, 2 trigger |
| rec_tstamp | output | 1 | Timestamp requested |
| rec_marked | output | 1 | Marked data packet |
| rec_guar | output | 1 | Guaranteed timing |
| rec_size | output | 2 | Size code of the payload |
| rec_data | output | 64 | Payload, zero above the size |

## Verification
A record is due on the clock edge after the edge that accepted its write. The bench raises the write strobe for exactly one edge and samples on the falling edge that follows. It therefore sees either the new record or, for a dropped write, a low valid. For stalls, the bench holds the consumer ready low and samples a few falling edges in a row to check that the record stays fixed and the bus ready stays low. It then releases the consumer and expects valid to be low one edge later. A port-enable write takes effect on the next edge, so each gating check follows its register write by one cycle.

// File: rtl/trace_port_decoder.sv
module trace_port_decoder #(
  parameter int ADDR_W   = 16,
  parameter int NUM_CHAN = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              trig_en,
  input  logic              cfg_wide,
  input  logic              pen_we,
  input  logic [31:0]       pen_wdata,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [1:0]        wr_size,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [ADDR_W-9:0] rec_chan,
  output logic [1:0]        rec_kind,
  output logic              rec_tstamp,
  output logic              rec_marked,
  output logic              rec_guar,
  output logic [1:0]        rec_size,
  output logic [63:0]       rec_data
);
  localparam int CHAN_W = ADDR_W - 8;
  localparam logic [1:0] K_DATA = 2'd0, K_FLAG = 2'd1, K_TRIG = 2'd2;

  logic [31:0] port_en;
  logic [7:0]  off;
  logic [CHAN_W-1:0] chan;
  logic is_data, is_flag, is_trig, chan_ok, size_ok, emit;
  logic [63:0] pay_mask;

  assign off     = wr_addr[7:0];
  assign chan    = wr_addr[ADDR_W-1:8];
  assign is_data = (off | 8'h98) == 8'h98;
  assign is_flag = (off | 8'h88) == 8'hE8;
  assign is_trig = (off | 8'h88) == 8'hF8;
  assign chan_ok = {1'b0, chan} < (CHAN_W+1)'(NUM_CHAN);
  assign size_ok = (wr_size != 2'd3) || cfg_wide;
  assign wr_ready = !rec_valid || rec_ready;
  assign emit = wr_valid && wr_ready && glb_en && chan_ok && port_en[chan[4:0]]
              && (is_flag || ((is_data || (is_trig && trig_en)) && size_ok));

  always_comb begin
    case (wr_size)
      2'd0:    pay_mask = 64'h0000_0000_0000_00FF;
      2'd1:    pay_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    pay_mask = 64'h0000_0000_FFFF_FFFF;
      default: pay_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) port_en <= 32'hFFFF_FFFF;
    else if (pen_we) port_en <= pen_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_chan <= '0;
      rec_kind <= K_DATA;
      rec_tstamp <= 1'b0;
      rec_marked <= 1'b0;
      rec_guar <= 1'b0;
      rec_size <= 2'd0;
      rec_data <= '0;
    end else if (emit) begin
      rec_valid  <= 1'b1;
      rec_chan   <= chan;
      rec_kind   <= is_data ? K_DATA : (is_flag ? K_FLAG : K_TRIG);
      rec_tstamp <= !off[3];
      rec_marked <= is_data && !off[4];
      rec_guar   <= !off[7];
      rec_size   <= is_flag ? 2'd0 : wr_size;
      rec_data   <= is_flag ? {56'd0, wr_data[7:0]} : (wr_data & pay_mask);
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  assert_reset_idle_R10: assert property (@(posedge clk) $past(!rst_n) |-> !rec_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_chan) && $stable(rec_data)
                                && $stable(rec_kind) && $stable(rec_size));
  assert_stall_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |-> !wr_ready);
  assert_flag_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_kind == K_FLAG |-> rec_size == 2'd0 && rec_data[63:8] == 56'd0);
  assert_mark_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_kind != K_DATA |-> !rec_marked);
  assert_chan_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> {1'b0, rec_chan} < (CHAN_W+1)'(NUM_CHAN));
  assert_glb_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> $past(glb_en));
  assert_kind_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_kind != 2'd3);
endmodule

// File: tb/trace_port_decoder_test.sv
module trace_port_decoder_test;
  logic clk = 0, rst_n = 0;
  logic glb_en = 1, trig_en = 0, cfg_wide = 0, pen_we = 0;
  logic [31:0] pen_wdata = 0;
  logic wr_valid = 0, wr_ready;
  logic [15:0] wr_addr = 0;
  logic [63:0] wr_data = 0;
  logic [1:0] wr_size = 0;
  logic rec_valid, rec_ready = 1;
  logic [7:0] rec_chan;
  logic [1:0] rec_kind, rec_size;
  logic rec_tstamp, rec_marked, rec_guar;
  logic [63:0] rec_data;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  trace_port_decoder #(.ADDR_W(16), .NUM_CHAN(200)) uut (
    .clk, .rst_n, .glb_en, .trig_en, .cfg_wide, .pen_we, .pen_wdata,
    .wr_valid, .wr_ready, .wr_addr, .wr_data, .wr_size,
    .rec_valid, .rec_ready, .rec_chan, .rec_kind, .rec_tstamp,
    .rec_marked, .rec_guar, .rec_size, .rec_data);

  localparam logic [63:0] D = 64'h1122_3344_5566_7788;

  task automatic check(input string tag, input logic [80:0] act, input logic [80:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [80:0] obs();
    return {rec_valid, rec_chan, rec_kind, rec_tstamp, rec_marked, rec_guar, rec_size, rec_data};
  endfunction

  function automatic logic [80:0] rec(input logic [7:0] ch, input logic [1:0] k,
      input logic ts, input logic mk, input logic gu, input logic [1:0] sz, input logic [63:0] d);
    return {1'b1, ch, k, ts, mk, gu, sz, d};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [1:0] s);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_size = s; wr_valid = 1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic t_reset();
    check("R10 idle", {obs(), 1'b0}, {81'd0, 1'b0});
    total++;
    if (wr_ready !== 1'b1) begin bad++; $display("FAIL R10 wr_ready actual=%b expected=1", wr_ready); end
  endtask

  task automatic t_data();
    wr(16'h0798, D, 2'd2);
    check("R1 R2 data", obs(), rec(8'h07, 2'd0, 0, 0, 0, 2'd2, 64'h5566_7788));
    wr(16'h1290, D, 2'd0);
    check("R3 ts", obs(), rec(8'h12, 2'd0, 1, 0, 0, 2'd0, 64'h88));
    wr(16'h1388, D, 2'd1);
    check("R3 marked", obs(), rec(8'h13, 2'd0, 0, 1, 0, 2'd1, 64'h7788));
    wr(16'h1418, D, 2'd1);
    check("R3 guar", obs(), rec(8'h14, 2'd0, 0, 0, 1, 2'd1, 64'h7788));
    wr(16'h1500, D, 2'd2);
    check("R3 all", obs(), rec(8'h15, 2'd0, 1, 1, 1, 2'd2, 64'h5566_7788));
    wr(16'h0599, D, 2'd0);
    check("R2 bad offset", {80'd0, rec_valid}, 81'd0);
    wr(16'h05A0, D, 2'd0);
    check("R2 bad offset2", {80'd0, rec_valid}, 81'd0);
  endtask

  task automatic t_size();
    wr(16'h0198, D, 2'd3);
    check("R4 wide off", {80'd0, rec_valid}, 81'd0);
    cfg_wide = 1;
    wr(16'h0198, D, 2'd3);
    check("R4 wide on", obs(), rec(8'h01, 2'd0, 0, 0, 0, 2'd3, D));
    cfg_wide = 0;
  endtask

  task automatic t_flag();
    wr(16'h02E8, D, 2'd2);
    check("R5 flag", obs(), rec(8'h02, 2'd1, 0, 0, 0, 2'd0, 64'h88));
    wr(16'h0360, D, 2'd3);
    check("R5 R3 flag opts", obs(), rec(8'h03, 2'd1, 1, 0, 1, 2'd0, 64'h88));
  endtask

  task automatic t_trig();
    wr(16'h04F8, D, 2'd0);
    check("R7 trig off", {80'd0, rec_valid}, 81'd0);
    trig_en = 1;
    wr(16'h04F0, D, 2'd1);
    check("R7 trig on", obs(), rec(8'h04, 2'd2, 1, 0, 0, 2'd1, 64'h7788));
    wr(16'h0478, D, 2'd0);
    check("R7 trig guar", obs(), rec(8'h04, 2'd2, 0, 0, 1, 2'd0, 64'h88));
    trig_en = 0;
  endtask

  task automatic t_gate();
    wr(16'hC798, D, 2'd0);
    check("R8 last chan", obs(), rec(8'hC7, 2'd0, 0, 0, 0, 2'd0, 64'h88));
    wr(16'hC898, D, 2'd0);
    check("R8 chan range", {80'd0, rec_valid}, 81'd0);
    glb_en = 0;
    wr(16'h0698, D, 2'd0);
    check("R8 glb off", {79'd0, rec_valid, wr_ready}, 81'd1);
    glb_en = 1;
    @(negedge clk); pen_we = 1; pen_wdata = ~(32'd1 << 5);
    @(negedge clk); pen_we = 0;
    wr(16'h2598, D, 2'd0);
    check("R6 chan37 off", {80'd0, rec_valid}, 81'd0);
    wr(16'h0598, D, 2'd0);
    check("R6 chan5 off", {80'd0, rec_valid}, 81'd0);
    wr(16'h2698, D, 2'd0);
    check("R6 chan38 on", obs(), rec(8'h26, 2'd0, 0, 0, 0, 2'd0, 64'h88));
    @(negedge clk); pen_we = 1; pen_wdata = 32'hFFFF_FFFF;
    @(negedge clk); pen_we = 0;
  endtask

  task automatic t_stall();
    logic [80:0] first;
    rec_ready = 0;
    wr(16'h0998, D, 2'd1);
    first = obs();
    check("R9 stall rec", first, rec(8'h09, 2'd0, 0, 0, 0, 2'd1, 64'h7788));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 held", {obs()}, first);
      check("R9 ready low", {80'd0, wr_ready}, 81'd0);
    end
    rec_ready = 1;
    @(negedge clk);
    check("R9 taken", {80'd0, rec_valid}, 81'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_size();
    t_flag();
    t_trig();
    t_gate();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule